// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out a set-vector-length operation in a single cycle. It holds two pieces of architectural state: the maximum vector length (MVL) and the current vector length (VL). Each operation can reload MVL from a small immediate and then derive a new VL. The VL comes from one of three sources, chosen by the register indices: a register value, the count register, or the immediate. VL is always clamped to MVL. When the operation asks for it, the result goes back to the target register, and a four-bit condition field is written. That field describes the new VL and flags a length request that MVL cut short.

The surrounding pipeline reads the register file and decodes the instruction. It presents one operation together with a one-cycle `op_valid` strobe. There is no back-pressure: the unit accepts every strobe in the cycle it is seen and never stalls. All results are registered. The new `mvl` and `vl` appear on the clock edge that samples the strobe. The register write (`rt_we`, `rt_data`) and the condition write (`cr_we`, `cr_flags`) are also produced on that edge, as one-cycle pulses. The immediate `svi` stands for a length of `svi + 1`, so it spans 1 to `MAX_VL`.

Top module: `vl_setter`

## Requirements
- R1: After synchronous reset, `mvl` and `vl` are 0, and `rt_we` and `cr_we` are low.
- R2: With `set_vl`=1 and a nonzero `ra_idx`, the new VL is min(MVL, `ra_val`). `rt_data` receives that VL with `rt_we` high exactly when `rt_idx` is nonzero.
- R3: With `set_vl`=1, `ra_idx`=0 and a nonzero `rt_idx`, the new VL is min(MVL, `ctr_val`), and `rt_data` receives it with `rt_we` high.
- R4: With `set_vl`=1 and both indices 0, the new VL is min(MVL, `svi`+1), and `rt_we` stays low.
- R5: With `set_mvl`=1, MVL becomes `svi`+1. The VL computed by the same operation is clamped against this new MVL.
- R6: With `set_vl`=0, outside the stepping encoding, VL becomes min(old VL, new MVL). If `rt_idx` is nonzero, that VL is returned on `rt_data` with `rt_we` high. With `set_mvl`=0 this is a pure read of VL.
- R7: The stepping encoding (`vert`=1, `set_vl`=0, `set_mvl`=0) changes no state and raises neither `rt_we` nor `cr_we`.
- R8: With `rc`=1 on any other operation, `cr_we` pulses. In `cr_flags`, bit 1 (EQ) is set when the new VL is 0, bit 2 (GT) is set when it is nonzero, and bit 3 (LT) is 0.
- R9: `cr_flags` bit 0 (SO) is set only when `set_vl`=1, the source is the count register or the immediate, and the requested length exceeds the new MVL. A length taken from `ra_val` never sets SO.
- R10: With `rc`=0, `cr_we` stays low.
- R11: Without `op_valid`, `mvl` and `vl` hold and both write pulses stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle strobe presenting an operation |
| set_vl | input | 1 | Operation sets VL from a selected source |
| set_mvl | input | 1 | Operation reloads MVL from the immediate |
| vert | input | 1 | Vertical stepping flag (stepping encoding is a no-op here) |
| rc | input | 1 | Request a condition field write |
| ra_idx | input | IDX_W | Source register index; 0 selects count or immediate |
| ra_val | input | XLEN | Source register value |
| rt_idx | input | IDX_W | Target register index; 0 means no write-back |
| ctr_val | input | XLEN | Count register value |
| svi | input | SVI_W | Immediate, meaning a length of svi+1 |
| mvl | output | LEN_W | Current maximum vector length |
| vl | output | LEN_W | Current vector length |
| rt_we | output | 1 | Target register write pulse |
| rt_data | output | XLEN | Value for the target register (zero-extended VL) |
| cr_we | output | 1 | Condition field write pulse |
| cr_flags | output | 4 | {LT, GT, EQ, SO} |

## Verification
The main function is driven with random mixes of zero and nonzero indices, so all three VL sources and both write-back choices occur. Source values are drawn both below and far above MVL, so the clamp and the overflow flag are seen from each side. MVL reloads are mixed with VL requests in the same operation, which shows whether the clamp uses the old or the new MVL. Directed cases cover VL landing at zero with MVL at zero, a count register value in the top bits, the largest immediate, the stepping no-op and idle cycles. Together these separate a wrongly chosen source, a missing SO flag and stray write pulses.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_REG  = 2'd1,
    SRC_CTR  = 2'd2,
    SRC_IMM  = 2'd3
  } vl_src_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_field_t;
endpackage

// File: rtl/vls_src_sel.sv
module vls_src_sel
  import vls_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5,
  parameter int SVI_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             set_vl,
  input  logic             set_mvl,
  input  logic             vert,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  ctr_val,
  input  logic [SVI_W-1:0] svi,
  input  logic [LEN_W-1:0] cur_mvl,
  input  logic [LEN_W-1:0] cur_vl,
  output logic [LEN_W-1:0] nxt_mvl,
  output logic [LEN_W-1:0] nxt_vl,
  output logic             ovf,
  output logic             step_op,
  output logic             rt_wr,
  output vl_src_e          src
);
  logic [LEN_W-1:0] imm_len;
  logic [XLEN-1:0]  req;
  logic [XLEN-1:0]  mvl_wide;
  logic             req_big;

  assign imm_len  = LEN_W'(svi) + LEN_W'(1);
  assign step_op  = vert && !set_vl && !set_mvl;
  assign nxt_mvl  = set_mvl ? imm_len : cur_mvl;
  assign mvl_wide = XLEN'(nxt_mvl);

  always_comb begin
    if (!set_vl)               src = SRC_KEEP;
    else if (ra_idx != '0)     src = SRC_REG;
    else if (rt_idx != '0)     src = SRC_CTR;
    else                       src = SRC_IMM;
  end

  always_comb begin
    unique case (src)
      SRC_REG: req = ra_val;
      SRC_CTR: req = ctr_val;
      SRC_IMM: req = XLEN'(imm_len);
      default: req = XLEN'(cur_vl);
    endcase
  end

  assign req_big = req > mvl_wide;
  assign nxt_vl  = req_big ? nxt_mvl : req[LEN_W-1:0];
  assign ovf     = req_big && (src == SRC_CTR || src == SRC_IMM);
  assign rt_wr   = !step_op && (rt_idx != '0);
endmodule

// File: rtl/vls_flags.sv
module vls_flags
  import vls_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic [LEN_W-1:0] nxt_vl,
  input  logic             ovf,
  output cr_field_t        flags
);
  always_comb begin
    flags.lt = 1'b0;
    flags.eq = (nxt_vl == '0);
    flags.gt = !flags.eq;
    flags.so = ovf;
  end
endmodule

// File: rtl/vls_state.sv
module vls_state
  import vls_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             step_op,
  input  logic             rc,
  input  logic             rt_wr,
  input  logic [LEN_W-1:0] nxt_mvl,
  input  logic [LEN_W-1:0] nxt_vl,
  input  cr_field_t        flags,
  output logic [LEN_W-1:0] mvl,
  output logic [LEN_W-1:0] vl,
  output logic             rt_we,
  output logic [XLEN-1:0]  rt_data,
  output logic             cr_we,
  output cr_field_t        cr_q
);
  logic take;
  assign take = op_valid && !step_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      mvl     <= '0;
      vl      <= '0;
      rt_we   <= 1'b0;
      rt_data <= '0;
      cr_we   <= 1'b0;
      cr_q    <= '0;
    end else begin
      rt_we <= take && rt_wr;
      cr_we <= take && rc;
      if (take) begin
        mvl     <= nxt_mvl;
        vl      <= nxt_vl;
        rt_data <= XLEN'(nxt_vl);
        cr_q    <= flags;
      end
    end
  end

  a_r2_vl_within_mvl: assert property (@(posedge clk) disable iff (rst)
    vl <= mvl);
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(mvl) && $stable(vl) && !rt_we && !cr_we));
  a_r10_no_cr_without_rc: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && rc) |=> !cr_we);
  a_r7_step_no_change: assert property (@(posedge clk) disable iff (rst)
    (op_valid && step_op) |=> ($stable(vl) && $stable(mvl) && !rt_we && !cr_we));
  a_r8_eq_tracks_vl: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> (cr_q.eq == (vl == '0) && cr_q.gt == (vl != '0) && !cr_q.lt));
  a_r6_rt_carries_vl: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> (rt_data == XLEN'(vl)));
endmodule

// File: rtl/vl_setter.sv
module vl_setter
  import vls_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IDX_W  = 5,
  parameter int MAX_VL = 64,
  parameter int SVI_W  = $clog2(MAX_VL),
  parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             set_vl,
  input  logic             set_mvl,
  input  logic             vert,
  input  logic             rc,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [XLEN-1:0]  ctr_val,
  input  logic [SVI_W-1:0] svi,
  output logic [LEN_W-1:0] mvl,
  output logic [LEN_W-1:0] vl,
  output logic             rt_we,
  output logic [XLEN-1:0]  rt_data,
  output logic             cr_we,
  output logic [3:0]       cr_flags
);
  logic [LEN_W-1:0] nxt_mvl;
  logic [LEN_W-1:0] nxt_vl;
  logic             ovf;
  logic             step_op;
  logic             rt_wr;
  vl_src_e          src;
  cr_field_t        flags;
  cr_field_t        cr_q;

  vls_src_sel #(
    .XLEN(XLEN), .IDX_W(IDX_W), .SVI_W(SVI_W), .LEN_W(LEN_W)
  ) u_sel (
    .set_vl(set_vl), .set_mvl(set_mvl), .vert(vert),
    .ra_idx(ra_idx), .rt_idx(rt_idx), .ra_val(ra_val), .ctr_val(ctr_val),
    .svi(svi), .cur_mvl(mvl), .cur_vl(vl),
    .nxt_mvl(nxt_mvl), .nxt_vl(nxt_vl), .ovf(ovf), .step_op(step_op),
    .rt_wr(rt_wr), .src(src)
  );

  vls_flags #(.LEN_W(LEN_W)) u_flags (
    .nxt_vl(nxt_vl), .ovf(ovf), .flags(flags)
  );

  vls_state #(.XLEN(XLEN), .LEN_W(LEN_W)) u_state (
    .clk(clk), .rst(rst), .op_valid(op_valid), .step_op(step_op), .rc(rc),
    .rt_wr(rt_wr), .nxt_mvl(nxt_mvl), .nxt_vl(nxt_vl), .flags(flags),
    .mvl(mvl), .vl(vl), .rt_we(rt_we), .rt_data(rt_data),
    .cr_we(cr_we), .cr_q(cr_q)
  );

  assign cr_flags = cr_q;

  a_r9_so_needs_ctr_or_imm: assert property (@(posedge clk) disable iff (rst)
    (op_valid && set_vl && ra_idx != '0) |=> !cr_flags[0]);
  a_r5_mvl_from_imm: assert property (@(posedge clk) disable iff (rst)
    (op_valid && set_mvl) |=> (mvl == LEN_W'($past(svi)) + LEN_W'(1)));
endmodule

// File: tb/vl_setter_tb.sv
module vl_setter_tb;
  localparam int XLEN = 64;
  localparam int IDX_W = 5;
  localparam int SVI_W = 6;
  localparam int LEN_W = 7;

  logic clk = 1'b0;
  logic rst;
  logic op_valid, set_vl, set_mvl, vert, rc;
  logic [IDX_W-1:0] ra_idx, rt_idx;
  logic [XLEN-1:0] ra_val, ctr_val;
  logic [SVI_W-1:0] svi;
  logic [LEN_W-1:0] mvl, vl;
  logic rt_we, cr_we;
  logic [XLEN-1:0] rt_data;
  logic [3:0] cr_flags;

  int errors = 0;
  int checks = 0;
  int m_mvl = 0;
  int m_vl = 0;

  always #2 clk = ~clk;

  vl_setter u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .set_vl(set_vl),
    .set_mvl(set_mvl), .vert(vert), .rc(rc), .ra_idx(ra_idx),
    .ra_val(ra_val), .rt_idx(rt_idx), .ctr_val(ctr_val), .svi(svi),
    .mvl(mvl), .vl(vl), .rt_we(rt_we), .rt_data(rt_data),
    .cr_we(cr_we), .cr_flags(cr_flags)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] clamp(logic [63:0] req, int lim);
    return (req > 64'(lim)) ? 64'(lim) : req;
  endfunction

  task automatic run_op(bit sv, bit sm, bit vf, bit c, int ra, logic [63:0] rav,
                        int rt, logic [63:0] ctr, int imm);
    logic [63:0] req;
    int nm, nv;
    bit step, e_rtwe, e_so;
    string tag;
    step = vf && !sv && !sm;
    nm = sm ? imm + 1 : m_mvl;
    e_so = 1'b0;
    if (!sv) begin
      req = 64'(m_vl);
      tag = "R6";
    end else if (ra != 0) begin
      req = rav;
      tag = "R2";
    end else if (rt != 0) begin
      req = ctr;
      tag = "R3";
      e_so = req > 64'(nm);
    end else begin
      req = 64'(imm + 1);
      tag = "R4";
      e_so = req > 64'(nm);
    end
    if (sm) tag = "R5";
    nv = int'(clamp(req, nm));
    e_rtwe = !step && rt != 0;
    @(negedge clk);
    op_valid = 1; set_vl = sv; set_mvl = sm; vert = vf; rc = c;
    ra_idx = IDX_W'(ra); ra_val = rav; rt_idx = IDX_W'(rt);
    ctr_val = ctr; svi = SVI_W'(imm);
    @(negedge clk);
    op_valid = 0;
    if (step) begin
      chk("R7 vl", 64'(vl), 64'(m_vl));
      chk("R7 mvl", 64'(mvl), 64'(m_mvl));
      chk("R7 rt_we", 64'(rt_we), 0);
      chk("R7 cr_we", 64'(cr_we), 0);
      return;
    end
    m_mvl = nm;
    m_vl = nv;
    chk({tag, " vl"}, 64'(vl), 64'(m_vl));
    chk({tag, " mvl"}, 64'(mvl), 64'(m_mvl));
    chk({tag, " rt_we"}, 64'(rt_we), 64'(e_rtwe));
    if (e_rtwe) chk({tag, " rt_data"}, rt_data, 64'(m_vl));
    if (c) begin
      chk("R8 cr_we", 64'(cr_we), 1);
      chk("R8 lt/gt/eq", 64'(cr_flags[3:1]), {61'b0, 1'b0, m_vl != 0, m_vl == 0});
      chk("R9 so", 64'(cr_flags[0]), 64'(e_so));
    end else begin
      chk("R10 cr_we", 64'(cr_we), 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; op_valid = 0; set_vl = 0; set_mvl = 0; vert = 0; rc = 0;
    ra_idx = 0; ra_val = 0; rt_idx = 0; ctr_val = 0; svi = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 mvl", 64'(mvl), 0);
    chk("R1 vl", 64'(vl), 0);
    chk("R1 rt_we", 64'(rt_we), 0);
    chk("R1 cr_we", 64'(cr_we), 0);

    // Directed corners
    run_op(1, 0, 0, 1, 0, 0, 0, 0, 9);          // R4: MVL=0 -> VL 0, EQ, SO
    run_op(1, 1, 0, 1, 0, 0, 0, 0, 63);         // R5: MVL=64, VL=64
    run_op(1, 0, 0, 1, 0, 0, 7, 64'hFFFF_0000_0000_0000, 0);  // R3 huge ctr, SO
    run_op(1, 0, 0, 1, 3, 64'h8000_0000_0000_0005, 2, 0, 0);  // R2 huge RA, no SO
    run_op(1, 1, 0, 1, 0, 0, 0, 0, 3);          // R5: MVL=4, imm 4, no SO
    run_op(0, 1, 0, 1, 0, 0, 4, 0, 1);          // R6: MVL shrinks to 2
    run_op(0, 0, 0, 1, 0, 0, 5, 0, 0);          // R6: read VL
    run_op(0, 0, 1, 1, 0, 0, 5, 0, 20);         // R7: stepping no-op
    run_op(1, 0, 0, 0, 0, 0, 9, 64'd1, 0);      // R3 with rc=0 (R10)
    // R11: idle cycles
    repeat (3) begin
      @(negedge clk);
      chk("R11 vl", 64'(vl), 64'(m_vl));
      chk("R11 rt_we", 64'(rt_we), 0);
      chk("R11 cr_we", 64'(cr_we), 0);
    end

    for (int i = 0; i < 400; i++) begin
      logic [63:0] rv, cv;
      int ra, rt;
      ra = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 31));
      rt = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 31));
      rv = ($urandom_range(0, 4) == 0) ? {$urandom, $urandom} : 64'($urandom_range(0, 80));
      cv = ($urandom_range(0, 4) == 0) ? {$urandom, $urandom} : 64'($urandom_range(0, 80));
      run_op(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0),
             1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)),
             ra, rv, rt, cv, int'($urandom_range(0, 63)));
      if ($urandom_range(0, 7) == 0) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule